// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block drives and samples a parameterised number of general-purpose pins, arranged in banks of up to 32. Each bank keeps its own output latch, direction bits, rising and falling edge enables, a sticky edge status word and an interrupt mask. Software changes outputs only through a write-one-to-set word and a write-one-to-clear word, so no read-modify-write of the latch is needed. Pending edges are removed by writing ones to the status word.

All banks share a simple register bus that completes one access per cycle. Writes take effect on the clock edge that samples them. Read data is registered and appears on `bus_rdata` in the cycle after the request. Pin inputs pass through a two-stage synchroniser before they are used. A single level interrupt is the OR of every status bit whose mask bit is set.

Top module: `bgpio_ctrl`

## Requirements
- R1: The byte address of a register is page*256 + (reg_code*3 + slot)*4, where bank = page*3 + slot. The reg_code values are: 0 level, 1 direction, 2 set, 3 clear, 4 rising enable, 5 falling enable, 6 status, 13 mask. Read data appears one cycle after the request. A misaligned address, a missing bank or an unused code reads zero and writes nothing.
- R2: Writing the set word drives every latch bit written as 1 high, and writing the clear word drives every such bit low. Bits written as 0 keep their latch value.
- R3: `gpio_oe` follows the direction bits (1 = output). `gpio_out` follows the latch. A level read returns the latch bit for output pins and the synchronised input for input pins.
- R4: A status bit is set one cycle after the synchronised input shows a 0-to-1 change while its rising enable is 1, or a 1-to-0 change while its falling enable is 1. Transitions whose enable is 0 leave the status unchanged.
- R5: Writing 1 to a status bit clears it. Status bits written as 0 are unchanged. Status bits clear only through such a write.
- R6: When an edge is detected on a bit in the same cycle that a clear of that bit is written, the bit stays set.
- R7: `irq` is 1 exactly when some bank has a status bit set whose mask bit is also set.
- R8: In the last bank, pin positions beyond the configured pin count read as zero and ignore writes. The set and clear words always read as zero.
- R9: After reset, the direction, latch, enable, mask and status words are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| gpio_in | input | NUM_PINS | Asynchronous pin inputs |
| gpio_out | output | NUM_PINS | Output latch values |
| gpio_oe | output | NUM_PINS | Output enables (direction bits) |
| irq | output | 1 | Combined masked edge interrupt |

## Verification
Two neighbouring pins are given opposite edge enables and are then moved up and down together. This separates rising detection from falling detection, and a wrong polarity or a crossed enable shows up as a wrong bit in the status word. A read of the level word on a bank with mixed direction, holding a latch pattern that differs from the input pattern, shows whether each bit comes from the latch or from the synchronised input. A clear write timed to land on the cycle an edge is detected shows whether a new event survives a clear issued at the same moment. Accesses to banks on the second page, to the short last bank, and to unused or misaligned addresses test the interleaved decode and the handling of unimplemented bits.

// File: rtl/bgpio_pkg.sv
package bgpio_pkg;
  localparam int unsigned BANK_BITS = 32;

  typedef enum logic [2:0] {
    RG_LEVEL, RG_DIR, RG_SET, RG_CLR, RG_RISE, RG_FALL, RG_STAT, RG_MASK
  } reg_e;

  localparam logic [4:0] CODE_MASK = 5'd13;
endpackage

// File: rtl/bgpio_sync.sv
module bgpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= (s == 0) ? d_i : stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bgpio_decode.sv
module bgpio_decode
  import bgpio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BANKS = 2,
  localparam int unsigned PAGE_W   = ADDR_W - 8,
  localparam int unsigned BIDX_W   = PAGE_W + 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output logic [BIDX_W-1:0] bank_o,
  output reg_e              reg_o
);
  logic [5:0] word;
  logic [4:0] code;
  logic [1:0] slot;
  logic       code_ok;

  assign word   = addr_i[7:2];
  assign code   = 5'(word / 6'd3);
  assign slot   = 2'(word % 6'd3);
  assign bank_o = {2'b00, addr_i[ADDR_W-1:8]} * BIDX_W'(3) + {{PAGE_W{1'b0}}, slot};

  always_comb begin
    code_ok = 1'b1;
    reg_o   = RG_LEVEL;
    case (code)
      5'd0:      reg_o = RG_LEVEL;
      5'd1:      reg_o = RG_DIR;
      5'd2:      reg_o = RG_SET;
      5'd3:      reg_o = RG_CLR;
      5'd4:      reg_o = RG_RISE;
      5'd5:      reg_o = RG_FALL;
      5'd6:      reg_o = RG_STAT;
      CODE_MASK: reg_o = RG_MASK;
      default:   code_ok = 1'b0;
    endcase
  end

  assign valid_o = code_ok && (addr_i[1:0] == 2'b00) &&
                   (bank_o < BIDX_W'(NUM_BANKS));
endmodule

// File: rtl/bgpio_bank.sv
module bgpio_bank
  import bgpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic         wr_en,
  input  reg_e         reg_sel,
  input  logic [W-1:0] wdata,
  output logic [31:0]  rdata,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic         irq_o
);
  logic [W-1:0] pin_s, pin_prev;
  logic [W-1:0] dir_q, latch_q, rise_q, fall_q, stat_q, mask_q;
  logic [W-1:0] edge_hit, clr_bits, level;

  bgpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  assign edge_hit = (pin_s & ~pin_prev & rise_q) | (~pin_s & pin_prev & fall_q);
  assign clr_bits = (wr_en && reg_sel == RG_STAT) ? wdata : '0;
  assign level    = (dir_q & latch_q) | (~dir_q & pin_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev <= '0;
      dir_q    <= '0;
      latch_q  <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      stat_q   <= '0;
      mask_q   <= '0;
    end else begin
      pin_prev <= pin_s;
      stat_q   <= (stat_q & ~clr_bits) | edge_hit;
      if (wr_en) begin
        case (reg_sel)
          RG_DIR:  dir_q   <= wdata;
          RG_SET:  latch_q <= latch_q | wdata;
          RG_CLR:  latch_q <= latch_q & ~wdata;
          RG_RISE: rise_q  <= wdata;
          RG_FALL: fall_q  <= wdata;
          RG_MASK: mask_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] pad(input logic [W-1:0] v);
    pad = '0;
    pad[W-1:0] = v;
  endfunction

  always_comb begin
    case (reg_sel)
      RG_LEVEL: rdata = pad(level);
      RG_DIR:   rdata = pad(dir_q);
      RG_RISE:  rdata = pad(rise_q);
      RG_FALL:  rdata = pad(fall_q);
      RG_STAT:  rdata = pad(stat_q);
      RG_MASK:  rdata = pad(mask_q);
      default:  rdata = '0;
    endcase
  end

  assign pin_o = latch_q;
  assign oe_o  = dir_q;
  assign irq_o = |(stat_q & mask_q);

  // R4 and R6: a detected edge always leaves its status bit set, clear or not
  a_r6_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

  // R5: a status bit falls only where a one was written to it
  a_r5_clear_only_by_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~stat_q) & ~$past(clr_bits)) == '0));

  // R2: a set write raises every latch bit written as one
  a_r2_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == RG_SET) |=> ((pin_o & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/bgpio_ctrl.sv
module bgpio_ctrl
  import bgpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] gpio_in,
  output logic [NUM_PINS-1:0] gpio_out,
  output logic [NUM_PINS-1:0] gpio_oe,
  output logic                irq
);
  localparam int unsigned NUM_BANKS = (NUM_PINS + BANK_BITS - 1) / BANK_BITS;
  localparam int unsigned LAST_W    = NUM_PINS - BANK_BITS * (NUM_BANKS - 1);
  localparam int unsigned BIDX_W    = ADDR_W - 8 + 2;

  logic              dec_valid;
  logic [BIDX_W-1:0] dec_bank;
  reg_e              dec_reg;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_irq;
  logic [31:0]       rd_mux;

  bgpio_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .addr_i(bus_addr), .valid_o(dec_valid), .bank_o(dec_bank), .reg_o(dec_reg)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BW = (b == NUM_BANKS - 1) ? LAST_W : BANK_BITS;
    logic bank_wr;
    assign bank_wr = bus_sel && bus_we && dec_valid && (dec_bank == BIDX_W'(b));

    bgpio_bank #(.W(BW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (gpio_in[b*BANK_BITS +: BW]),
      .wr_en   (bank_wr),
      .reg_sel (dec_reg),
      .wdata   (bus_wdata[BW-1:0]),
      .rdata   (bank_rd[b]),
      .pin_o   (gpio_out[b*BANK_BITS +: BW]),
      .oe_o    (gpio_oe[b*BANK_BITS +: BW]),
      .irq_o   (bank_irq[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (dec_bank == BIDX_W'(b)) rd_mux = bank_rd[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                bus_rdata <= '0;
    else if (bus_sel && !bus_we && dec_valid)  bus_rdata <= rd_mux;
    else                                       bus_rdata <= '0;
  end

  assign irq = |bank_irq;

  // R1: a read of an address outside the map returns zero next cycle
  a_r1_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !dec_valid) |=> (bus_rdata == '0));
endmodule

// File: tb/bgpio_ctrl_tb_top.sv
module bgpio_ctrl_tb_top;
  localparam int NP = 136;
  localparam int AW = 12;
  localparam int O_LVL = 0, O_DIR = 12, O_SET = 24, O_CLR = 36;
  localparam int O_RISE = 48, O_FALL = 60, O_STAT = 72, O_MASK = 156;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] gpio_in = '0;
  logic [NP-1:0] gpio_out, gpio_oe;
  logic          irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bgpio_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
  );

  function automatic logic [AW-1:0] ra(int bank, int off);
    return AW'(((bank / 3) << 8) + ((bank % 3) << 2) + off);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(ra(0, O_DIR), d);  check("R9 dir", d, 0);
    rd(ra(4, O_RISE), d); check("R9 rise", d, 0);
    rd(ra(1, O_STAT), d); check("R9 stat", d, 0);
    rd(ra(3, O_MASK), d); check("R9 mask", d, 0);
    check("R9 oe", {31'b0, |gpio_oe}, 0);
    check("R9 out", {31'b0, |gpio_out}, 0);
    check("R9 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_dir_latch();
    logic [31:0] d;
    gpio_in[127:96] = 32'h1234_5678;
    wr(ra(3, O_DIR), 32'hFFFF_0000);
    wr(ra(3, O_SET), 32'hA5A5_A5A5);
    check("R2 set", gpio_out[127:96], 32'hA5A5_A5A5);
    check("R3 oe", gpio_oe[127:96], 32'hFFFF_0000);
    wr(ra(3, O_CLR), 32'h0000_FFFF);
    check("R2 clear", gpio_out[127:96], 32'hA5A5_0000);
    settle();
    rd(ra(3, O_LVL), d); check("R3 level mix", d, 32'hA5A5_5678);
    rd(ra(3, O_DIR), d); check("R1 page1 dir", d, 32'hFFFF_0000);
    rd(ra(3, O_SET), d); check("R8 set reads 0", d, 0);
    rd(ra(3, O_CLR), d); check("R8 clr reads 0", d, 0);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    wr(ra(1, O_RISE), 32'h1);
    wr(ra(1, O_FALL), 32'h2);
    gpio_in[33:32] = 2'b11; settle();
    rd(ra(1, O_STAT), d); check("R4 rise only", d, 32'h1);
    gpio_in[33:32] = 2'b00; settle();
    rd(ra(1, O_STAT), d); check("R4 fall", d, 32'h3);
    check("R7 masked irq", {31'b0, irq}, 0);
    wr(ra(1, O_STAT), 32'h1);
    rd(ra(1, O_STAT), d); check("R5 w1c", d, 32'h2);
    wr(ra(1, O_STAT), 32'h0);
    rd(ra(1, O_STAT), d); check("R5 zero write", d, 32'h2);
    wr(ra(1, O_STAT), 32'hFFFF_FFFF);
    rd(ra(1, O_STAT), d); check("R5 clear all", d, 0);
  endtask

  task automatic t_irq();
    gpio_in[33] = 1; settle();
    gpio_in[33] = 0; settle();
    check("R7 no mask", {31'b0, irq}, 0);
    wr(ra(1, O_MASK), 32'h1);
    check("R7 other bit", {31'b0, irq}, 0);
    wr(ra(1, O_MASK), 32'h2);
    check("R7 irq high", {31'b0, irq}, 1);
    wr(ra(1, O_STAT), 32'h2);
    check("R7 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    wr(ra(0, O_RISE), 32'h20);
    gpio_in[5] = 1; settle();
    gpio_in[5] = 0; settle();
    rd(ra(0, O_STAT), d); check("R4 first event", d, 32'h20);
    @(negedge clk); gpio_in[5] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = ra(0, O_STAT); bus_wdata = 32'h20;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    rd(ra(0, O_STAT), d); check("R6 edge kept", d, 32'h20);
    wr(ra(0, O_STAT), 32'h20);
    rd(ra(0, O_STAT), d); check("R6 later clear", d, 0);
  endtask

  task automatic t_last_bank();
    logic [31:0] d;
    wr(ra(4, O_DIR), 32'hFFFF_FFFF);
    rd(ra(4, O_DIR), d); check("R8 short dir", d, 32'hFF);
    wr(ra(4, O_RISE), 32'hFFFF_FFFF);
    rd(ra(4, O_RISE), d); check("R8 short rise", d, 32'hFF);
    wr(ra(4, O_SET), 32'hFFFF_FFFF);
    check("R8 short out", {24'b0, gpio_out[135:128]}, 32'hFF);
    rd(ra(4, O_LVL), d); check("R8 short level", d, 32'hFF);
    rd(AW'(12'h054), d); check("R1 unused code", d, 0);
    rd(AW'(12'h208), d); check("R1 no bank", d, 0);
    rd(AW'(12'h00D), d); check("R1 misaligned", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_dir_latch();
    t_edges();
    t_irq();
    t_same_cycle();
    t_last_bank();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule